// File: doc/BRIEF.md
# Click interval classifier

This block watches one button line that already changes at most once per clock cycle, so it is sampled directly with no synchroniser or filter. It measures how many clock edges pass between two consecutive rising edges of that line. It then reports the result as a single-cycle pulse on one of two outputs. A short gap gives a fast double click. A medium gap gives two separate clicks. A long gap gives no pulse.

Internally, a two-state controller (idle, or armed after a first rising edge) steers a small datapath. The datapath holds the previous line value, an edge detector, a saturating cycle timer and two less-than comparators. The controller acts only on the edge flag and the two comparator results.

Top module: `click_gap_classifier`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, both outputs are 0. The block is idle, and the stored previous key value is 0.
- R2: A rising edge is detected at a clock edge where `key` is 1 and the `key` value sampled at the previous clock edge was 0. Holding `key` high for several cycles produces only one rising edge.
- R3: A rising edge that arrives while idle arms the block, clears the timer and produces no output pulse.
- R4: The gap is the number of clock edges strictly between the edge that armed the block and the edge that samples the next rising edge. If the gap is below FAST_LIMIT (default 6), `double_click` is 1 for the one cycle after that second edge.
- R5: If the gap is at least FAST_LIMIT and below SLOW_LIMIT (default 12), `two_clicks` is 1 for the one cycle after the second edge. A gap of exactly 6 therefore gives `two_clicks`.
- R6: If the gap is SLOW_LIMIT or more, neither output pulses on the second edge.
- R7: Every pulse lasts exactly one cycle. After the second edge the block is idle again, so the next rising edge starts a new pair.
- R8: The timer saturates at its maximum value and does not wrap. A gap far longer than SLOW_LIMIT (for example 100) never yields a pulse.
- R9: `double_click` and `two_clicks` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| key | input | 1 | Button line, at most one change per cycle |
| double_click | output | 1 | One-cycle pulse for a gap below FAST_LIMIT |
| two_clicks | output | 1 | One-cycle pulse for a gap from FAST_LIMIT up to SLOW_LIMIT-1 |

## Verification
The closing rising edge of a pair can land in the same cycle that the timer sits at its saturated value. In that cycle the classification must still read "long" and must not treat a wrapped count as a short one. The bench provokes this with directed gaps of 15, 40 and 100 cycles, which drive the 4-bit timer into saturation before the second press. Random presses add further such cases. Each outcome is judged against a bench model that counts edges between presses and classifies the gap from the limits alone.

// File: rtl/click_gap_classifier.sv
module click_gap_classifier #(
  parameter int FAST_LIMIT = 6,
  parameter int SLOW_LIMIT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key,
  output logic double_click,
  output logic two_clicks
);
  localparam int TIMER_W = $clog2(SLOW_LIMIT + 1);
  localparam logic [TIMER_W-1:0] TIMER_MAX = {TIMER_W{1'b1}};
  localparam logic [TIMER_W-1:0] FAST_T = TIMER_W'(FAST_LIMIT);
  localparam logic [TIMER_W-1:0] SLOW_T = TIMER_W'(SLOW_LIMIT);

  logic               prev_q;
  logic               armed_q;
  logic [TIMER_W-1:0] timer_q;
  logic               dbl_q, two_q;

  wire rise     = key & ~prev_q;
  wire below_f  = timer_q < FAST_T;
  wire below_s  = timer_q < SLOW_T;
  wire at_max   = timer_q == TIMER_MAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      timer_q <= '0;
      dbl_q   <= 1'b0;
      two_q   <= 1'b0;
    end else begin
      prev_q <= key;
      dbl_q  <= 1'b0;
      two_q  <= 1'b0;
      if (!armed_q) begin
        if (rise) begin
          armed_q <= 1'b1;
          timer_q <= '0;
        end
      end else if (rise) begin
        armed_q <= 1'b0;
        dbl_q   <= below_f;
        two_q   <= ~below_f & below_s;
      end else if (!at_max) begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign double_click = dbl_q;
  assign two_clicks   = two_q;
endmodule

// File: rtl/click_gap_classifier_chk.sv
module click_gap_classifier_chk #(
  parameter int TIMER_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               key,
  input logic               armed,
  input logic [TIMER_W-1:0] timer,
  input logic               double_click,
  input logic               two_clicks
);
  localparam logic [TIMER_W-1:0] TMAX = {TIMER_W{1'b1}};

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(double_click && two_clicks));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (double_click || two_clicks) |=> !(double_click || two_clicks));

  p_pulse_needs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (double_click || two_clicks) |-> ($past(key) && !armed));

  p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !key) |=> !(double_click || two_clicks));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && timer == TMAX) |=> (timer == TMAX || !armed));

  p_arm_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> (timer == '0));
endmodule

bind click_gap_classifier click_gap_classifier_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key(key), .armed(armed_q), .timer(timer_q),
  .double_click(double_click), .two_clicks(two_clicks)
);

// File: tb/click_gap_classifier_tb_top.sv
`timescale 1ns/1ps
module click_gap_classifier_tb_top;
  localparam int FAST = 6;
  localparam int SLOW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key = 1'b0;
  logic double_click, two_clicks;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit m_prev = 1'b0, m_armed = 1'b0;
  int cyc = 0, first_cyc = 0;
  bit exp_d, exp_t;
  string tag;

  always #5 clk = ~clk;

  click_gap_classifier #(.FAST_LIMIT(FAST), .SLOW_LIMIT(SLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .key(key),
    .double_click(double_click), .two_clicks(two_clicks)
  );

  function automatic bit want_double(int gap);
    return gap < FAST;
  endfunction

  function automatic bit want_two(int gap);
    return gap >= FAST && gap < SLOW;
  endfunction

  task automatic check(string t);
    n_checks++;
    if (double_click !== exp_d || two_clicks !== exp_t) begin
      n_fail++;
      $display("FAIL %s: got dbl=%0b two=%0b, expected dbl=%0b two=%0b at cycle %0d",
               t, double_click, two_clicks, exp_d, exp_t, cyc);
    end
  endtask

  task automatic step(bit k);
    int gap;
    bit rise;
    key = k;
    cyc++;
    rise = k && !m_prev;
    exp_d = 0; exp_t = 0;
    tag = (k && m_prev) ? "R2" : "R7";
    if (rise && m_armed) begin
      gap = cyc - first_cyc - 1;
      exp_d = want_double(gap);
      exp_t = want_two(gap);
      m_armed = 0;
      if (gap > 15) tag = "R8";
      else if (exp_d) tag = "R4";
      else if (exp_t) tag = "R5";
      else tag = "R6";
    end else if (rise) begin
      m_armed = 1;
      first_cyc = cyc;
      tag = "R3";
    end
    m_prev = k;
    @(posedge clk);
    @(negedge clk);
    check(tag);
    if (double_click && two_clicks) begin
      n_fail++;
      $display("FAIL R9: both outputs high, expected at most one");
    end
  endtask

  task automatic pulse(int h, int l);
    for (int i = 0; i < h; i++) step(1'b1);
    for (int i = 0; i < l; i++) step(1'b0);
  endtask

  task automatic do_reset();
    key = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp_d = 0; exp_t = 0;
    check("R1 in reset");
    rst_n = 1'b1;
    m_prev = 0; m_armed = 0;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check("R1 after reset");
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h1c2a7));
    @(negedge clk);
    do_reset();
    step(0); step(0);
    // R4/R5 boundaries: gap = h + l - 1
    pulse(1, 5); pulse(1, 3);          // gap 5 -> double
    pulse(1, 6); pulse(1, 3);          // gap 6 -> two
    pulse(1, 1); pulse(1, 3);          // gap 1 -> double
    pulse(1, 11); pulse(1, 3);         // gap 11 -> two
    pulse(1, 12); pulse(1, 3);         // gap 12 -> none (R6)
    pulse(10, 3); pulse(1, 3);         // R2 held high, gap 12 -> none
    pulse(1, 15); pulse(1, 3);         // R8 saturation boundary
    pulse(1, 40); pulse(1, 3);         // R8
    pulse(1, 100); pulse(1, 3);        // R8 long gap
    // R1 mid-pair reset drops the armed state
    pulse(1, 3);
    do_reset();
    pulse(1, 2); pulse(1, 3);
    for (int n = 0; n < 400; n++) begin
      int h, l;
      h = 1 + int'($urandom_range(2));
      l = ($urandom_range(7) == 0) ? 12 + int'($urandom_range(30))
                                    : 1 + int'($urandom_range(14));
      pulse(h, l);
    end
    step(0); step(0);
    finish_up();
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end
endmodule